// File: doc/BRIEF.md
# GPU Command Packet Framer

This block sits in front of a rendering engine and turns a flat stream of 32-bit command words into whole packets. Words arrive one per valid/ready handshake. The top byte of a packet's first word is its opcode. A fixed per-opcode table gives the number of extra words that follow the opcode. The framer collects the packet and then presents all of its words at once on a wide output, together with a one-cycle strobe and the packet's word count.

Two opcode families are also handled inside the framer. Opcodes 0xE0 to 0xE7 store their whole word in one of eight environment registers. Two bits of register 6 and eleven bits of register 1 form a status field. Opcodes 0xA0 (write rectangle into video memory) and 0xC0 (read rectangle from video memory) are three-word packets. They leave on a separate rectangle-transfer port and never on the packet port.

While a packet is only partly received, a flag is raised and the words are held until the rest arrive. The input stalls while a downstream video-memory write transfer is active. A command-clear input discards a partial packet.

Top module: `gpu_cmd_framer`

## Requirements
- R1: A packet is issued one clock after its last word is accepted. `pkt_valid` is high for one cycle, `pkt_len` holds the total word count, and word k of the packet appears at `pkt_data[32k+31:32k]`. Unused slots read zero.
- R2: Total length is 1 plus an extra count taken from the opcode (bits 31:24 of the first word):
  - 0x02 has 2 extra words.
  - 0x20–0x3F, in groups of four opcodes, have 3, 6, 4, 8, 5, 8, 7, 11.
  - 0x40–0x5F, in groups of eight, have 2, 3, 3, 4.
  - 0x60–0x7F, in groups of four, have 2, 3, 1, 0, 1, 2, 1, 2.
- R3: Opcode 0x80 has 3 extra words. Opcodes 0xA0 and 0xC0 have 2. Every other opcode, including 0x00 and 0xE0–0xEF, has 0.
- R4: A word whose opcode is 0xE0–0xE7 is stored in environment register opcode[2:0]. It is visible on `env_regs[32i+31:32i]` one clock after acceptance, and it is also issued as a one-word packet. Opcodes 0xE8–0xEF leave all environment registers unchanged.
- R5: A 0xA0 or 0xC0 packet is not issued on the packet port. One clock after its third word, `xfer_valid` pulses for one cycle, with `xfer_pos` set to word 1, `xfer_size` set to word 2, and `xfer_rd` set to 1 for 0xC0 and 0 for 0xA0.
- R6: While fewer words than needed have arrived, nothing is issued, `pkt_partial` is 1, and the held words are kept until the packet completes.
- R7: `stat_bits[10:0]` equals environment register 1 bits 10:0, and `stat_bits[12:11]` equals environment register 6 bits 1:0.
- R8: After reset, environment register i holds (0xE0+i)<<24. After reset, no packet or transfer is pending, `pkt_partial` is 0 and `in_ready` is 1.
- R9: While `img_wr_busy` is 1, `in_ready` is 0 and a word presented on the input is not taken.
- R10: A one-cycle `cmd_clr` pulse empties the word buffer. After it, `pkt_partial` is 0 and the next word starts a new packet. `in_ready` is 0 while `cmd_clr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_clr | input | 1 | Discard buffered words |
| img_wr_busy | input | 1 | Video-memory write transfer active; stalls input |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high with in_valid |
| pkt_valid | output | 1 | Packet strobe |
| pkt_data | output | 384 | Packet words, word 0 in the low bits |
| pkt_len | output | 4 | Packet word count |
| pkt_partial | output | 1 | Incomplete packet held |
| xfer_valid | output | 1 | Rectangle transfer strobe |
| xfer_pos | output | 32 | Rectangle position word |
| xfer_size | output | 32 | Rectangle size word |
| xfer_rd | output | 1 | 1 = read from video memory |
| env_regs | output | 256 | Eight environment registers, register i at bits 32i+31:32i |
| stat_bits | output | 13 | Status field built from registers 1 and 6 |

## Verification
Some properties are checked by assertions on every cycle:
- An issued packet's length agrees with the table entry for its opcode.
- Image opcodes never reach the packet port.
- Transfer strobes never occur on adjacent cycles or together with a packet.
- The input stalls whenever a write transfer is busy, and a clear leaves no partial packet.
- Every environment register keeps its own opcode byte.

The bench's scenarios are the only checks of the remaining behaviour:
- The table values themselves.
- Data placement in the packet.
- The status field mapping.
- The hold of partial words.
- The fact that a stalled or cleared word leaves no trace.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
  localparam int WORD_W  = 32;
  localparam int PKT_MAX = 12;
  localparam int LEN_W   = 4;
  localparam int ENV_N   = 8;

  function automatic logic [LEN_W-1:0] extra_words(input logic [7:0] op);
    logic [LEN_W-1:0] n;
    n = '0;
    case (op[7:5])
      3'b000: if (op[4:0] == 5'h02) n = 4'd2;
      3'b001: begin
        case (op[4:2])
          3'd0: n = 4'd3;
          3'd1: n = 4'd6;
          3'd2: n = 4'd4;
          3'd3: n = 4'd8;
          3'd4: n = 4'd5;
          3'd5: n = 4'd8;
          3'd6: n = 4'd7;
          default: n = 4'd11;
        endcase
      end
      3'b010: begin
        case (op[4:3])
          2'd0: n = 4'd2;
          2'd3: n = 4'd4;
          default: n = 4'd3;
        endcase
      end
      3'b011: begin
        case (op[4:2])
          3'd0: n = 4'd2;
          3'd1: n = 4'd3;
          3'd3: n = 4'd0;
          3'd5: n = 4'd2;
          3'd7: n = 4'd2;
          default: n = 4'd1;
        endcase
      end
      3'b100: if (op[4:0] == 5'h00) n = 4'd3;
      3'b101, 3'b110: if (op[4:0] == 5'h00) n = 4'd2;
      default: n = '0;
    endcase
    return n;
  endfunction

  function automatic logic is_img_op(input logic [7:0] op);
    return (op == 8'hA0) || (op == 8'hC0);
  endfunction

  function automatic logic is_env_op(input logic [7:0] op);
    return op[7:3] == 5'b11100;
  endfunction
endpackage

// File: rtl/gpf_rst_sync.sv
module gpf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gpf_collect.sv
module gpf_collect
  import gpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      img_busy,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_data,
  output logic                      in_ready,
  output logic                      pkt_valid,
  output logic [PKT_MAX*WORD_W-1:0] pkt_data,
  output logic [LEN_W-1:0]          pkt_len,
  output logic                      partial,
  output logic                      xfer_valid,
  output logic [WORD_W-1:0]         xfer_pos,
  output logic [WORD_W-1:0]         xfer_size,
  output logic                      xfer_rd,
  output logic                      cap_en,
  output logic [WORD_W-1:0]         cap_word
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][WORD_W-1:0]   buf_q;
  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic [PKT_MAX-1:0][WORD_W-1:0] asm_d;
  logic                           take, last, img;
  logic [7:0]                     op;
  logic [LEN_W-1:0]               need;

  assign in_ready = (cnt_q != CNT_W'(DEPTH)) && !img_busy && !clr;
  assign take     = in_valid && in_ready;
  assign op       = (cnt_q == '0) ? in_data[31:24] : buf_q[0][31:24];
  assign need     = LEN_W'(1) + extra_words(op);
  assign last     = take && ((cnt_q + CNT_W'(1)) == CNT_W'(need));
  assign img      = is_img_op(op);
  assign partial  = (cnt_q != '0);
  assign cap_en   = last && is_env_op(op);
  assign cap_word = in_data;

  // next-state for the word count
  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  // packet assembly: stored words below the count, new word at the count
  for (genvar k = 0; k < PKT_MAX; k++) begin : g_asm
    always_comb begin
      if (CNT_W'(k) < cnt_q)       asm_d[k] = buf_q[k];
      else if (CNT_W'(k) == cnt_q) asm_d[k] = in_data;
      else                         asm_d[k] = '0;
    end
  end

  // word storage, one clock enable per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_buf
    logic wr_en;
    assign wr_en = take && !last && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) buf_q[i] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pkt_valid  <= 1'b0;
      xfer_valid <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      pkt_valid  <= last && !img;
      xfer_valid <= last && img;
    end
  end

  always_ff @(posedge clk) begin
    if (last && !img) begin
      pkt_data <= asm_d;
      pkt_len  <= need;
    end
    if (last && img) begin
      xfer_pos  <= buf_q[1];
      xfer_size <= in_data;
      xfer_rd   <= (op == 8'hC0);
    end
  end

  // R2
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len == LEN_W'(1) + extra_words(pkt_data[31:24])));
  // R5
  no_img_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !is_img_op(pkt_data[31:24]));
  // R5
  xfer_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid);
  // R5
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && pkt_valid));
  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_busy |-> !in_ready);
  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !partial);
endmodule

// File: rtl/gpf_env_bank.sv
module gpf_env_bank
  import gpf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [WORD_W-1:0]       cap_word,
  output logic [ENV_N*WORD_W-1:0] env_flat,
  output logic [12:0]             stat
);
  logic [ENV_N-1:0][WORD_W-1:0] env_q;

  for (genvar i = 0; i < ENV_N; i++) begin : g_env
    logic en;
    assign en = cap_en && (cap_word[26:24] == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  env_q[i] <= {8'(8'hE0 + i), 24'h0};
      else if (en) env_q[i] <= cap_word;
    end
    // R4
    env_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      env_q[i][31:24] == 8'(8'hE0 + i));
  end

  assign env_flat = env_q;
  assign stat     = {env_q[6][1:0], env_q[1][10:0]};
endmodule

// File: rtl/gpu_cmd_framer.sv
module gpu_cmd_framer
  import gpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_clr,
  input  logic                      img_wr_busy,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_data,
  output logic                      in_ready,
  output logic                      pkt_valid,
  output logic [PKT_MAX*WORD_W-1:0] pkt_data,
  output logic [LEN_W-1:0]          pkt_len,
  output logic                      pkt_partial,
  output logic                      xfer_valid,
  output logic [WORD_W-1:0]         xfer_pos,
  output logic [WORD_W-1:0]         xfer_size,
  output logic                      xfer_rd,
  output logic [ENV_N*WORD_W-1:0]   env_regs,
  output logic [12:0]               stat_bits
);
  logic              rst_n_sync;
  logic              cap_en;
  logic [WORD_W-1:0] cap_word;

  gpf_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  gpf_collect #(.DEPTH(DEPTH)) u_collect (
    .clk(clk), .rst_n(rst_n_sync), .clr(cmd_clr), .img_busy(img_wr_busy),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_len(pkt_len),
    .partial(pkt_partial), .xfer_valid(xfer_valid), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_rd(xfer_rd),
    .cap_en(cap_en), .cap_word(cap_word)
  );

  gpf_env_bank u_env (
    .clk(clk), .rst_n(rst_n_sync), .cap_en(cap_en), .cap_word(cap_word),
    .env_flat(env_regs), .stat(stat_bits)
  );
endmodule

// File: tb/gpu_cmd_framer_tb.sv
`timescale 1ns/100ps
module gpu_cmd_framer_tb;
  logic         clk = 1'b0;
  logic         rst_n, cmd_clr, img_wr_busy, in_valid;
  logic [31:0]  in_data;
  logic         in_ready, pkt_valid, pkt_partial, xfer_valid, xfer_rd;
  logic [383:0] pkt_data;
  logic [3:0]   pkt_len;
  logic [31:0]  xfer_pos, xfer_size;
  logic [255:0] env_regs;
  logic [12:0]  stat_bits;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] pw [12];

  always #2.5 clk = ~clk;

  gpu_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_clr(cmd_clr), .img_wr_busy(img_wr_busy),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_len(pkt_len),
    .pkt_partial(pkt_partial), .xfer_valid(xfer_valid), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_rd(xfer_rd), .env_regs(env_regs),
    .stat_bits(stat_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sends pw[0..n-1], checks hold then issue
  task automatic send_pkt(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      send_word(pw[k]);
      if (k < n - 1) begin
        chk(pkt_valid == 1'b0, "R6 no early issue", 64'(pkt_valid), 0);
        chk(pkt_partial == 1'b1, "R6 partial flag", 64'(pkt_partial), 1);
      end
    end
    chk(pkt_valid == 1'b1, {req, " issued"}, 64'(pkt_valid), 1);
    chk(pkt_len == 4'(n), {req, " length"}, 64'(pkt_len), 64'(n));
    for (int k = 0; k < 12; k++) begin
      logic [31:0] e;
      e = (k < n) ? pw[k] : 32'h0;
      chk(pkt_data[32*k +: 32] == e, "R1 packet word", 64'(pkt_data[32*k +: 32]), 64'(e));
    end
    chk(pkt_partial == 1'b0, "R1 partial cleared", 64'(pkt_partial), 0);
  endtask

  task automatic fill_pw(input logic [7:0] op, input int n);
    for (int k = 0; k < 12; k++)
      pw[k] = (k == 0) ? {op, 24'h00AB00} + 32'(n) : 32'h1000_0000 + 32'(k * 17 + n);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R8 ready", 64'(in_ready), 1);
    chk(pkt_valid == 1'b0, "R8 no packet", 64'(pkt_valid), 0);
    chk(xfer_valid == 1'b0, "R8 no transfer", 64'(xfer_valid), 0);
    chk(pkt_partial == 1'b0, "R8 no partial", 64'(pkt_partial), 0);
    for (int i = 0; i < 8; i++)
      chk(env_regs[32*i +: 32] == {8'(8'hE0 + i), 24'h0}, "R8 env reset",
          64'(env_regs[32*i +: 32]), 64'({8'(8'hE0 + i), 24'h0}));
    chk(stat_bits == 13'h0, "R7 status at reset", 64'(stat_bits), 0);
  endtask

  task automatic t_lengths;
    fill_pw(8'h02, 3); send_pkt(3, "R2 fill");
    fill_pw(8'h3C, 12); send_pkt(12, "R2 longest");
    fill_pw(8'h2C, 9); send_pkt(9, "R2 0x2C");
    fill_pw(8'h25, 7); send_pkt(7, "R2 0x25");
    fill_pw(8'h48, 4); send_pkt(4, "R2 0x48");
    fill_pw(8'h5B, 5); send_pkt(5, "R2 0x5B");
    fill_pw(8'h6C, 1); send_pkt(1, "R2 0x6C");
    fill_pw(8'h64, 4); send_pkt(4, "R2 0x64");
    fill_pw(8'h80, 4); send_pkt(4, "R3 0x80");
    fill_pw(8'h00, 1); send_pkt(1, "R3 0x00");
    fill_pw(8'hE8, 1); send_pkt(1, "R3 0xE8");
    for (int i = 0; i < 8; i++)
      chk(env_regs[32*i +: 32] == {8'(8'hE0 + i), 24'h0}, "R4 0xE8 ignored",
          64'(env_regs[32*i +: 32]), 64'({8'(8'hE0 + i), 24'h0}));
  endtask

  task automatic t_env;
    pw[0] = 32'hE100_07FF; send_pkt(1, "R4 env1 packet");
    chk(env_regs[63:32] == 32'hE100_07FF, "R4 env1", 64'(env_regs[63:32]), 64'hE100_07FF);
    pw[0] = 32'hE600_0003; send_pkt(1, "R4 env6 packet");
    chk(env_regs[223:192] == 32'hE600_0003, "R4 env6", 64'(env_regs[223:192]), 64'hE600_0003);
    chk(stat_bits == 13'h1FFF, "R7 status all ones", 64'(stat_bits), 64'h1FFF);
    pw[0] = 32'hE1FF_F955; send_pkt(1, "R4 env1 rewrite");
    chk(stat_bits == 13'h1955, "R7 status mix", 64'(stat_bits), 64'h1955);
    chk(env_regs[95:64] == 32'hE200_0000, "R4 env2 untouched", 64'(env_regs[95:64]), 64'hE200_0000);
  endtask

  task automatic t_image;
    send_word(32'hA000_0000);
    send_word(32'h0010_0020);
    chk(xfer_valid == 1'b0, "R5 no early transfer", 64'(xfer_valid), 0);
    chk(pkt_partial == 1'b1, "R6 image partial", 64'(pkt_partial), 1);
    send_word(32'h0008_0010);
    chk(xfer_valid == 1'b1, "R5 write strobe", 64'(xfer_valid), 1);
    chk(pkt_valid == 1'b0, "R5 not on packet port", 64'(pkt_valid), 0);
    chk(xfer_pos == 32'h0010_0020, "R5 position", 64'(xfer_pos), 64'h0010_0020);
    chk(xfer_size == 32'h0008_0010, "R5 size", 64'(xfer_size), 64'h0008_0010);
    chk(xfer_rd == 1'b0, "R5 write flag", 64'(xfer_rd), 0);
    send_word(32'hC000_0000);
    chk(xfer_valid == 1'b0, "R5 one-cycle strobe", 64'(xfer_valid), 0);
    send_word(32'h0003_0004);
    send_word(32'h0001_0002);
    chk(xfer_valid == 1'b1, "R5 read strobe", 64'(xfer_valid), 1);
    chk(xfer_rd == 1'b1, "R5 read flag", 64'(xfer_rd), 1);
    chk(xfer_pos == 32'h0003_0004, "R5 read position", 64'(xfer_pos), 64'h0003_0004);
    chk(pkt_valid == 1'b0, "R5 read not on packet port", 64'(pkt_valid), 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    img_wr_busy = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9 stalled", 64'(in_ready), 0);
    send_word(32'h6C00_0000);
    chk(pkt_valid == 1'b0, "R9 word not taken", 64'(pkt_valid), 0);
    chk(pkt_partial == 1'b0, "R9 nothing buffered", 64'(pkt_partial), 0);
    @(negedge clk);
    img_wr_busy = 1'b0;
    pw[0] = 32'h6C00_0001; send_pkt(1, "R9 resumed");
  endtask

  task automatic t_clr;
    send_word(32'h3C00_0000);
    send_word(32'h1111_1111);
    chk(pkt_partial == 1'b1, "R10 partial before clear", 64'(pkt_partial), 1);
    @(negedge clk);
    cmd_clr = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10 ready low in clear", 64'(in_ready), 0);
    @(negedge clk);
    cmd_clr = 1'b0;
    chk(pkt_partial == 1'b0, "R10 partial cleared", 64'(pkt_partial), 0);
    pw[0] = 32'h6C00_000A; send_pkt(1, "R10 fresh packet");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_clr = 1'b0; img_wr_busy = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lengths();
    t_env();
    t_image();
    t_busy();
    t_clr();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule